// File: doc/BRIEF.md
# Floating-Point Operation Sequencer

This block is the control shell around a 64-bit floating-point arithmetic datapath. A requester places two operands, a 3-bit operation select and a 2-bit rounding select on the inputs. It then drives the enable level high for two clock cycles and drops it again. When the sequencer sees enable rise while it is idle, it latches every input, issues a one-cycle start pulse to the datapath, and presents the latched values to the datapath for the whole operation.

A down-counter is loaded with a terminal count that depends on the operation. When the count runs out, the sequencer registers the datapath result and its five status flags and raises ready. Ready and the registered outputs then hold until the next operation starts. An operation select that names no arithmetic operation skips the datapath. It completes after one cycle with a quiet NaN and the invalid flag.

The datapath itself sits outside this block. Operand and result words use bit 63 as sign, bits 62..52 as exponent and bits 51..0 as fraction. The sequencer passes these words through unchanged.

Top module: `fp_op_sequencer`

## Requirements
- R1: A synchronous reset clears ready, the result word, all five flags and the datapath start pulse to 0.
- R2: A start is a cycle in which enable is sampled high, was sampled low in the previous cycle, and no operation is in flight. On that edge the inputs are latched. For an arithmetic select, dp_start is high for exactly the one cycle after that edge.
- R3: Ready rises L clock edges after the start edge. L is 20 for select 000 (add), 21 for 001 (subtract), 24 for 010 (multiply) and 71 for 011 (divide).
- R4: Selects 100 through 111 give no dp_start. Ready rises 1 edge after the start edge. The result is 64'h7FF8000000000000, invalid is 1, and underflow, overflow, inexact and exception are 0.
- R5: For an arithmetic select, the result and the flags underflow, overflow, inexact, exception and invalid equal the datapath values present at the completing edge.
- R6: Changes on the operand, operation and rounding inputs after the start edge have no effect. dp_a, dp_b, dp_op and the final result reflect only the latched values.
- R7: Enable that stays high past the start cycle does not start another operation. Enable that rises again while an operation is in flight is ignored.
- R8: Ready and the result and flag outputs stay constant from completion until the next start. Ready is low from the start edge onward.
- R9: The latched rounding select reaches dp_rmode unchanged during the operation: 00 nearest, 01 toward zero, 10 toward plus infinity, 11 toward minus infinity.
- R10: A reset during an operation cancels it, and ready does not rise for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Start level, held two cycles |
| op_sel | input | 3 | Operation select |
| rmode_sel | input | 2 | Rounding select |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand |
| dp_start | output | 1 | One-cycle start pulse toward the datapath |
| dp_op | output | 3 | Latched operation select |
| dp_rmode | output | 2 | Latched rounding select |
| dp_a | output | 64 | Latched first operand |
| dp_b | output | 64 | Latched second operand |
| dp_result | input | 64 | Datapath result |
| dp_uflow | input | 1 | Datapath underflow flag |
| dp_oflow | input | 1 | Datapath overflow flag |
| dp_inexact | input | 1 | Datapath inexact flag |
| dp_except | input | 1 | Datapath exception flag |
| dp_invalid | input | 1 | Datapath invalid flag |
| result | output | 64 | Registered result |
| ready | output | 1 | Result available |
| uflow | output | 1 | Registered underflow |
| oflow | output | 1 | Registered overflow |
| inexact | output | 1 | Registered inexact |
| except_o | output | 1 | Registered exception |
| invalid | output | 1 | Registered invalid |

## Verification
The bench drives enable on a falling edge, so the start is taken on the next rising edge. From there dp_start is due one edge later. Ready and the result are due L edges later: 20, 21, 24 or 71 for the arithmetic selects and 1 for the unused ones. A behavioural model, stepped on each rising edge from the bench's own inputs, predicts every output. The bench compares the model with the design on every falling edge, so every check samples half a cycle after the edge that should have changed the value. The bench also counts falling edges from the start to the ready rise and compares that count with L. This catches an off-by-one in the counter even if it were mirrored in a looser check.

// File: rtl/fpseq_pkg.sv
package fpseq_pkg;

    localparam int FP_W = 64;
    localparam logic [FP_W-1:0] QUIET_NAN = 64'h7FF8_0000_0000_0000;

    typedef enum logic [2:0] {
        OPC_ADD = 3'b000,
        OPC_SUB = 3'b001,
        OPC_MUL = 3'b010,
        OPC_DIV = 3'b011
    } opc_e;

    typedef struct packed {
        logic uf;
        logic of;
        logic ix;
        logic ex;
        logic iv;
    } fp_flags_t;

endpackage

// File: rtl/fpseq_decode.sv
module fpseq_decode #(
    parameter int LAT_ADD = 20,
    parameter int LAT_SUB = 21,
    parameter int LAT_MUL = 24,
    parameter int LAT_DIV = 71,
    parameter int CNT_W   = 7
) (
    input  logic [2:0]       op_i,
    output logic             valid_o,
    output logic [CNT_W-1:0] load_o
);
    import fpseq_pkg::*;

    // Counter load is latency minus one: completion happens on the edge after reaching 0.
    always_comb begin
        valid_o = 1'b1;
        load_o  = '0;
        case (op_i)
            OPC_ADD: load_o = CNT_W'(LAT_ADD - 1);
            OPC_SUB: load_o = CNT_W'(LAT_SUB - 1);
            OPC_MUL: load_o = CNT_W'(LAT_MUL - 1);
            OPC_DIV: load_o = CNT_W'(LAT_DIV - 1);
            default: begin
                valid_o = 1'b0;
                load_o  = '0;
            end
        endcase
    end

endmodule

// File: rtl/fpseq_timer.sv
module fpseq_timer #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             busy_o,
    output logic             done_o
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    assign busy_o = st_q.busy;
    assign done_o = st_q.busy && (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = load_val_i;
        end else if (done_o) begin
            st_d.busy = 1'b0;
        end else if (st_q.busy) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R3: the count steps down by one each cycle while running
    p_countdown_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q.busy && st_q.cnt != '0 && !load_i) |=>
        (st_q.busy && st_q.cnt == $past(st_q.cnt) - CNT_W'(1)));

    // R3: expiry ends the run
    p_expire_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (done_o && !load_i) |=> !st_q.busy);

    // R7: a new load never lands on a running count
    p_load_idle_r7: assert property (@(posedge clk) disable iff (rst)
        load_i |-> !st_q.busy);

endmodule

// File: rtl/fpseq_opreg.sv
module fpseq_opreg #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_i,
    input  logic [2:0]        op_i,
    input  logic [1:0]        rnd_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [2:0]        op_o,
    output logic [1:0]        rnd_o,
    output logic [DATA_W-1:0] a_o,
    output logic [DATA_W-1:0] b_o
);
    typedef struct packed {
        logic [2:0]        op;
        logic [1:0]        rnd;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
    } opnd_t;

    opnd_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap_i) begin
            st_d.op  = op_i;
            st_d.rnd = rnd_i;
            st_d.a   = a_i;
            st_d.b   = b_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign op_o  = st_q.op;
    assign rnd_o = st_q.rnd;
    assign a_o   = st_q.a;
    assign b_o   = st_q.b;

    // R6: latched values move only on a capture
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !cap_i |=> ($stable(a_o) && $stable(b_o) && $stable(op_o) && $stable(rnd_o)));

endmodule

// File: rtl/fp_op_sequencer.sv
module fp_op_sequencer #(
    parameter int DATA_W  = 64,
    parameter int LAT_ADD = 20,
    parameter int LAT_SUB = 21,
    parameter int LAT_MUL = 24,
    parameter int LAT_DIV = 71
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [2:0]        op_sel,
    input  logic [1:0]        rmode_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic              dp_start,
    output logic [2:0]        dp_op,
    output logic [1:0]        dp_rmode,
    output logic [DATA_W-1:0] dp_a,
    output logic [DATA_W-1:0] dp_b,
    input  logic [DATA_W-1:0] dp_result,
    input  logic              dp_uflow,
    input  logic              dp_oflow,
    input  logic              dp_inexact,
    input  logic              dp_except,
    input  logic              dp_invalid,
    output logic [DATA_W-1:0] result,
    output logic              ready,
    output logic              uflow,
    output logic              oflow,
    output logic              inexact,
    output logic              except_o,
    output logic              invalid
);
    import fpseq_pkg::*;

    localparam int MAX_AS  = (LAT_ADD > LAT_SUB) ? LAT_ADD : LAT_SUB;
    localparam int MAX_MD  = (LAT_MUL > LAT_DIV) ? LAT_MUL : LAT_DIV;
    localparam int MAX_LAT = (MAX_AS > MAX_MD) ? MAX_AS : MAX_MD;
    localparam int CNT_W   = $clog2(MAX_LAT + 1);
    localparam logic [DATA_W-1:0] NAN_WORD = DATA_W'(QUIET_NAN);

    typedef struct packed {
        logic              en_q;
        logic              rdy;
        logic              valid;
        logic              go;
        logic [DATA_W-1:0] res;
        fp_flags_t         flg;
    } seq_t;

    seq_t st_d, st_q;

    logic             start;
    logic             dec_valid;
    logic [CNT_W-1:0] dec_load;
    logic             t_busy;
    logic             t_done;

    assign start = en && !st_q.en_q && !t_busy;

    fpseq_decode #(
        .LAT_ADD (LAT_ADD),
        .LAT_SUB (LAT_SUB),
        .LAT_MUL (LAT_MUL),
        .LAT_DIV (LAT_DIV),
        .CNT_W   (CNT_W)
    ) u_dec (
        .op_i    (op_sel),
        .valid_o (dec_valid),
        .load_o  (dec_load)
    );

    fpseq_timer #(
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk        (clk),
        .rst        (rst),
        .load_i     (start),
        .load_val_i (dec_load),
        .busy_o     (t_busy),
        .done_o     (t_done)
    );

    fpseq_opreg #(
        .DATA_W (DATA_W)
    ) u_opr (
        .clk   (clk),
        .rst   (rst),
        .cap_i (start),
        .op_i  (op_sel),
        .rnd_i (rmode_sel),
        .a_i   (opnd_a),
        .b_i   (opnd_b),
        .op_o  (dp_op),
        .rnd_o (dp_rmode),
        .a_o   (dp_a),
        .b_o   (dp_b)
    );

    always_comb begin
        st_d      = st_q;
        st_d.en_q = en;
        st_d.go   = start && dec_valid;
        if (start) begin
            st_d.rdy   = 1'b0;
            st_d.valid = dec_valid;
        end else if (t_done) begin
            st_d.rdy = 1'b1;
            if (st_q.valid) begin
                st_d.res    = dp_result;
                st_d.flg.uf = dp_uflow;
                st_d.flg.of = dp_oflow;
                st_d.flg.ix = dp_inexact;
                st_d.flg.ex = dp_except;
                st_d.flg.iv = dp_invalid;
            end else begin
                st_d.res = NAN_WORD;
                st_d.flg = '{uf: 1'b0, of: 1'b0, ix: 1'b0, ex: 1'b0, iv: 1'b1};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dp_start = st_q.go;
    assign result   = st_q.res;
    assign ready    = st_q.rdy;
    assign uflow    = st_q.flg.uf;
    assign oflow    = st_q.flg.of;
    assign inexact  = st_q.flg.ix;
    assign except_o = st_q.flg.ex;
    assign invalid  = st_q.flg.iv;

    // R8: ready falls on the start edge
    p_ready_drop_r8: assert property (@(posedge clk) disable iff (rst)
        start |=> !ready);

    // R8: ready and outputs hold until a start
    p_ready_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (ready && !start) |=> (ready && $stable(result) && $stable(invalid)));

    // R4: unused select ends with the quiet NaN and invalid
    p_bad_op_r4: assert property (@(posedge clk) disable iff (rst)
        (t_done && !st_q.valid) |=> (result == NAN_WORD && invalid && !uflow && !oflow));

    // R2: the datapath start is a single-cycle pulse
    p_go_single_r2: assert property (@(posedge clk) disable iff (rst)
        dp_start |=> !dp_start);

    // R7: a start always leaves the timer running
    p_busy_after_start_r7: assert property (@(posedge clk) disable iff (rst)
        start |=> t_busy);

endmodule

// File: tb/tb_fp_op_sequencer.sv
module tb_fp_op_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [1:0]  rmode_sel = '0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic        dp_start;
    logic [2:0]  dp_op;
    logic [1:0]  dp_rmode;
    logic [63:0] dp_a, dp_b, dp_result, result;
    logic        dp_uflow, dp_oflow, dp_inexact, dp_except, dp_invalid;
    logic        ready, uflow, oflow, inexact, except_o, invalid;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    // Behavioural datapath stub
    function automatic logic [63:0] stub_res(logic [2:0] o, logic [1:0] r, logic [63:0] a, logic [63:0] b);
        return a ^ {b[31:0], b[63:32]} ^ {59'd0, r, o};
    endfunction
    function automatic logic [4:0] stub_flg(logic [2:0] o, logic [1:0] r, logic [63:0] a, logic [63:0] b);
        return {a[0] ^ b[1], a[2], b[3], r[0], o[0]};
    endfunction

    assign dp_result = stub_res(dp_op, dp_rmode, dp_a, dp_b);
    assign {dp_uflow, dp_oflow, dp_inexact, dp_except, dp_invalid} = stub_flg(dp_op, dp_rmode, dp_a, dp_b);

    fp_op_sequencer dut (
        .clk(clk), .rst(rst), .en(en), .op_sel(op_sel), .rmode_sel(rmode_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .dp_start(dp_start), .dp_op(dp_op),
        .dp_rmode(dp_rmode), .dp_a(dp_a), .dp_b(dp_b), .dp_result(dp_result),
        .dp_uflow(dp_uflow), .dp_oflow(dp_oflow), .dp_inexact(dp_inexact),
        .dp_except(dp_except), .dp_invalid(dp_invalid), .result(result),
        .ready(ready), .uflow(uflow), .oflow(oflow), .inexact(inexact),
        .except_o(except_o), .invalid(invalid)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    function automatic int lat_of(logic [2:0] o);
        case (o)
            3'd0: return 20;
            3'd1: return 21;
            3'd2: return 24;
            3'd3: return 71;
            default: return 1;
        endcase
    endfunction

    // Reference model, stepped on rising edges from bench inputs only
    logic        m_started = 1'b0;
    logic        m_busy, m_rdy, m_go, m_prev;
    int          m_left;
    logic [2:0]  m_op;
    logic [1:0]  m_rnd;
    logic [63:0] m_a, m_b, m_res;
    logic [4:0]  m_flg;

    always @(posedge clk) begin
        cyc++;
        m_started = 1'b1;
        if (rst) begin
            m_busy = 0; m_rdy = 0; m_go = 0; m_prev = 0; m_left = 0;
            m_op = 0; m_rnd = 0; m_a = 0; m_b = 0; m_res = 0; m_flg = 0;
        end else begin
            m_go = 1'b0;
            if (en && !m_prev && !m_busy) begin
                m_op = op_sel; m_rnd = rmode_sel; m_a = opnd_a; m_b = opnd_b;
                m_rdy = 1'b0; m_busy = 1'b1; m_left = lat_of(op_sel);
                m_go = (op_sel < 3'd4);
            end else if (m_busy) begin
                m_left--;
                if (m_left == 0) begin
                    m_busy = 1'b0;
                    m_rdy  = 1'b1;
                    if (m_op < 3'd4) begin
                        m_res = stub_res(m_op, m_rnd, m_a, m_b);
                        m_flg = stub_flg(m_op, m_rnd, m_a, m_b);
                    end else begin
                        m_res = 64'h7FF8_0000_0000_0000;
                        m_flg = 5'b00001;
                    end
                end
            end
            m_prev = en;
        end
    end

    // Per-cycle comparison, half a cycle after each rising edge
    always @(negedge clk) begin
        if (m_started) begin
            chk("R3 ready", {63'd0, ready}, {63'd0, m_rdy});
            chk("R5 result", result, m_res);
            chk("R5 flags", {59'd0, uflow, oflow, inexact, except_o, invalid}, {59'd0, m_flg});
            chk("R2 dp_start", {63'd0, dp_start}, {63'd0, m_go});
            if (m_busy) begin
                chk("R6 dp_a", dp_a, m_a);
                chk("R6 dp_b", dp_b, m_b);
                chk("R6 dp_op", {61'd0, dp_op}, {61'd0, m_op});
                chk("R9 dp_rmode", {62'd0, dp_rmode}, {62'd0, m_rnd});
            end
        end
    end

    // Run one operation; returns edges from start to ready
    task automatic run_op(input logic [2:0] o, input logic [1:0] r, input logic [63:0] a,
                          input logic [63:0] b, input bit scramble, input int hold,
                          input bit rerise, output int lat);
        int k;
        @(negedge clk);
        op_sel = o; rmode_sel = r; opnd_a = a; opnd_b = b; en = 1'b1;
        @(negedge clk);
        k = 1;
        chk("R8 ready low after start", {63'd0, ready}, 64'd0);
        if (scramble) begin
            op_sel = ~o; rmode_sel = ~r; opnd_a = ~a; opnd_b = a ^ b;
        end
        lat = 1;
        while (!ready || k < hold) begin
            if (k == hold) en = 1'b0;
            if (rerise && k == hold + 3) en = 1'b1;
            if (rerise && k == hold + 5) en = 1'b0;
            @(negedge clk);
            k++;
            if (!ready) lat++;
            if (cyc > 150000) break;
        end
        en = 1'b0;
    endtask

    initial begin : watchdog
        wait (cyc > 150000);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int lat;
        logic [63:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 ready", {63'd0, ready}, 64'd0);
        chk("R1 result", result, 64'd0);
        chk("R1 flags", {59'd0, uflow, oflow, inexact, except_o, invalid}, 64'd0);
        chk("R1 dp_start", {63'd0, dp_start}, 64'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R3, R5, R9: each arithmetic select with each rounding select
        for (int i = 0; i < 4; i++) begin
            run_op(3'(i), 2'(i), 64'h3FF0_0000_0000_0000 + 64'(i * 77), 64'hC008_0000_0000_1234, 0, 2, 0, lat);
            chk("R3 latency", 64'(lat), 64'(lat_of(3'(i))));
        end
        run_op(3'd2, 2'd3, 64'h7FEF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 0, 2, 0, lat);
        chk("R3 latency mul", 64'(lat), 64'd24);

        // R4: all unused selects
        for (int i = 4; i < 8; i++) begin
            run_op(3'(i), 2'd1, 64'h1234_5678_9ABC_DEF0, 64'h8000_0000_0000_0000, 0, 2, 0, lat);
            chk("R4 latency", 64'(lat), 64'd1);
            chk("R4 result", result, 64'h7FF8_0000_0000_0000);
            chk("R4 invalid", {59'd0, uflow, oflow, inexact, except_o, invalid}, 64'd1);
        end

        // R6: inputs scrambled after the start edge
        run_op(3'd1, 2'd2, 64'hAAAA_5555_0F0F_F0F0, 64'h0123_4567_89AB_CDEF, 1, 2, 0, lat);
        chk("R6 result from latched", result,
            stub_res(3'd1, 2'd2, 64'hAAAA_5555_0F0F_F0F0, 64'h0123_4567_89AB_CDEF));
        chk("R6 latency", 64'(lat), 64'd21);

        // R7: long enable hold and a re-rise while in flight
        run_op(3'd0, 2'd0, 64'h4000_0000_0000_0000, 64'h4010_0000_0000_0000, 0, 6, 1, lat);
        chk("R7 latency unchanged", 64'(lat), 64'd20);

        // R8: outputs hold while idle
        held = result;
        repeat (7) @(negedge clk);
        chk("R8 ready held", {63'd0, ready}, 64'd1);
        chk("R8 result held", result, held);

        // R10: reset in the middle of a divide
        @(negedge clk);
        op_sel = 3'd3; en = 1'b1;
        repeat (2) @(negedge clk);
        en = 1'b0;
        repeat (8) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        lat = 0;
        repeat (80) begin
            @(negedge clk);
            if (ready) lat++;
        end
        chk("R10 no completion after reset", 64'(lat), 64'd0);

        // Recovery after reset
        run_op(3'd3, 2'd1, 64'hBFF8_0000_0000_0000, 64'h3FE0_0000_0000_0000, 0, 2, 0, lat);
        chk("R3 latency div after reset", 64'(lat), 64'd71);

        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule